// File: doc/BRIEF.md
# Instruction Fetch and Branch Address Unit

This unit produces the memory address for a small 8-bit machine with 16-bit instructions. A pointer register names the next instruction byte in a 256-byte memory. The unit steps through a repeating three-phase cycle. In the two fetch phases the pointer drives the memory address. Each returned byte goes into one half of an instruction register, and the pointer advances by one after each byte. In the third phase the memory address comes from a separate data-address input, and the returned byte is captured in a data register.

In that third phase the unit also decodes the assembled instruction. An unconditional relative branch adds the sign-extended low byte of the instruction to the pointer. A carry-qualified branch does the same only when the carry input is high. The memory is outside the block. It must return `mem_rdata` for `mem_addr` combinationally within the same cycle. The pointer and all additions wrap modulo 256.

Top module: `fbu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the pointer, the instruction register and the data register all become 0, and `phase` becomes 0.
- R2: `phase` runs 0 (first fetch), 1 (second fetch), 2 (execute), and then back to 0, advancing once per clock.
- R3: In phases 0 and 1, `mem_addr` equals `ip`. In phase 2, `mem_addr` equals `data_addr`.
- R4: At the end of each fetch phase, `ip` increases by 1 modulo 256, so 255 is followed by 0.
- R5: A byte fetched from an even address is stored in `instr[15:8]`, and a byte fetched from an odd address is stored in `instr[7:0]`. This holds even when an instruction starts at an odd address.
- R6: At the end of phase 2, `data_byte` takes the value of `mem_rdata`, and `instr` does not change.
- R7: When `instr[15:12]` is 4'b1100, `ip` becomes `ip` plus the two's-complement value of `instr[7:0]` at the end of phase 2.
- R8: When `instr[15:12]` is 4'b1110, the R7 adjustment is made only if `carry_in` is 1 during phase 2. Otherwise `ip` is unchanged.
- R9: For every other opcode, `ip` is unchanged at the end of phase 2, and `carry_in` has no effect on it.
- R10: A branch sum that goes past 255 or below 0 wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 8 | Byte returned by memory for `mem_addr` |
| data_addr | input | 8 | Operand address used in the execute phase |
| carry_in | input | 1 | Carry flag that qualifies the conditional branch |
| mem_addr | output | 8 | Memory address |
| phase | output | 2 | Current phase: 0, 1 fetch; 2 execute |
| ip | output | 8 | Instruction pointer |
| instr | output | 16 | Assembled instruction |
| data_byte | output | 8 | Byte captured in the execute phase |

## Verification
The properties assume that reset is held for at least one edge before the first cycle they check. They also assume that memory answers within the cycle, so that a fetched byte depends only on the address in the same phase. `data_addr` and `carry_in` are taken to matter only in phase 2. The stimulus therefore changes them only just after an edge, with a combinational memory model. Instruction bytes are placed at addresses chosen by their parity, including a pair that straddles address 255 and 0 and instructions that start at odd addresses after odd branches.

// File: rtl/fbu_pkg.sv
`timescale 1ns/1ps
package fbu_pkg;
   // Default opcode field width and branch opcodes
   localparam int unsigned FBU_OP_W = 4;
   localparam logic [FBU_OP_W-1:0] FBU_OP_JMP = 4'b1100;
   localparam logic [FBU_OP_W-1:0] FBU_OP_JC  = 4'b1110;

   // Kind of pointer adjustment in the execute phase
   typedef enum logic [1:0] {
      BR_NONE     = 2'd0,
      BR_ALWAYS   = 2'd1,
      BR_ON_CARRY = 2'd2
   } br_kind_e;
endpackage

// File: rtl/fbu_phase_seq.sv
`timescale 1ns/1ps
// Cyclic phase counter: fetch slots 0..NPH-2, then one execute slot
module fbu_phase_seq #(
   parameter int unsigned NPH = 3,
   parameter int unsigned PW  = 2
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] phase,
   output logic          fetch,
   output logic          exec
);
   localparam logic [PW-1:0] LAST = PW'(NPH - 1);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + PW'(1);
   end

   assign phase = cnt;
   assign exec  = (cnt == LAST);
   assign fetch = ~exec;
endmodule

// File: rtl/fbu_lanes.sv
`timescale 1ns/1ps
// Instruction byte lanes selected by low address bits, plus the data byte
module fbu_lanes #(
   parameter int unsigned DW = 8,
   parameter int unsigned IW = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      fetch_we,
   input  logic                      exec_we,
   input  logic [((IW/DW)>1 ? $clog2(IW/DW) : 1)-1:0] lane,
   input  logic [DW-1:0]             rd,
   output logic [IW-1:0]             instr,
   output logic [DW-1:0]             data_q
);
   localparam int unsigned NL = IW / DW;
   localparam int unsigned LW = (NL > 1) ? $clog2(NL) : 1;

   // Lane 0 (address LSBs zero) holds the most significant byte
   for (genvar k = 0; k < NL; k++) begin : g_lane
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)                                 q <= '0;
         else if (fetch_we && lane == LW'(k))     q <= rd;
      end
      assign instr[IW-1-k*DW -: DW] = q;
   end

   always_ff @(posedge clk) begin
      if (rst)          data_q <= '0;
      else if (exec_we) data_q <= rd;
   end
endmodule

// File: rtl/fbu_ptr.sv
`timescale 1ns/1ps
// Instruction pointer: unit step during fetch, signed offset on a taken branch
module fbu_ptr #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  logic          take,
   input  logic [DW-1:0] off,
   output logic [AW-1:0] ip
);
   logic [AW-1:0] off_ext;
   assign off_ext = AW'($signed(off));

   always_ff @(posedge clk) begin
      if (rst)       ip <= '0;
      else if (step) ip <= ip + AW'(1);
      else if (take) ip <= ip + off_ext;
   end
endmodule

// File: rtl/fbu_top.sv
`timescale 1ns/1ps
module fbu_top
   import fbu_pkg::*;
#(
   parameter int unsigned     AW     = 8,
   parameter int unsigned     DW     = 8,
   parameter int unsigned     IW     = 16,
   parameter int unsigned     OP_W   = FBU_OP_W,
   parameter logic [OP_W-1:0] OP_JMP = FBU_OP_JMP,
   parameter logic [OP_W-1:0] OP_JC  = FBU_OP_JC,
   localparam int unsigned    NB     = IW / DW,
   localparam int unsigned    PW     = $clog2(NB + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] mem_rdata,
   input  logic [AW-1:0] data_addr,
   input  logic          carry_in,
   output logic [AW-1:0] mem_addr,
   output logic [PW-1:0] phase,
   output logic [AW-1:0] ip,
   output logic [IW-1:0] instr,
   output logic [DW-1:0] data_byte
);
   localparam int unsigned LW = (NB > 1) ? $clog2(NB) : 1;

   initial begin
      if (IW % DW != 0)      $fatal(1, "instruction width must be a multiple of the byte width");
      if (NB < 2)            $fatal(1, "an instruction needs at least two bytes");
      if (OP_W + DW > IW)    $fatal(1, "opcode and offset fields overlap");
      if (LW > AW)           $fatal(1, "address too narrow for lane select");
   end

   logic     fetch, exec, take;
   br_kind_e kind;

   fbu_phase_seq #(.NPH(NB + 1), .PW(PW)) u_seq (
      .clk(clk), .rst(rst), .phase(phase), .fetch(fetch), .exec(exec)
   );

   // Address mux: pointer while fetching, operand address while executing
   assign mem_addr = exec ? data_addr : ip;

   fbu_lanes #(.DW(DW), .IW(IW)) u_lanes (
      .clk(clk), .rst(rst), .fetch_we(fetch), .exec_we(exec),
      .lane(mem_addr[LW-1:0]), .rd(mem_rdata),
      .instr(instr), .data_q(data_byte)
   );

   // Branch decode
   always_comb begin
      unique case (instr[IW-1 -: OP_W])
         OP_JMP:  kind = BR_ALWAYS;
         OP_JC:   kind = BR_ON_CARRY;
         default: kind = BR_NONE;
      endcase
   end

   assign take = exec && ((kind == BR_ALWAYS) || (kind == BR_ON_CARRY && carry_in));

   fbu_ptr #(.AW(AW), .DW(DW)) u_ptr (
      .clk(clk), .rst(rst), .step(fetch), .take(take),
      .off(instr[DW-1:0]), .ip(ip)
   );
endmodule

// File: rtl/fbu_chk.sv
`timescale 1ns/1ps
module fbu_chk #(
   parameter int unsigned     AW     = 8,
   parameter int unsigned     DW     = 8,
   parameter int unsigned     IW     = 16,
   parameter int unsigned     PW     = 2,
   parameter int unsigned     OP_W   = 4,
   parameter logic [OP_W-1:0] OP_JMP = 4'b1100,
   parameter logic [OP_W-1:0] OP_JC  = 4'b1110
) (
   input logic          clk,
   input logic          rst,
   input logic          carry_in,
   input logic [AW-1:0] data_addr,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] ip,
   input logic [PW-1:0] phase,
   input logic [IW-1:0] instr
);
   localparam logic [PW-1:0] PH_EXEC = PW'(IW / DW);

   logic [OP_W-1:0] op;
   assign op = instr[IW-1 -: OP_W];

   // R2
   phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      phase == PH_EXEC |=> phase == '0);
   // R2
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      phase != PH_EXEC |=> phase == PW'($past(phase) + 1'b1));
   // R3
   fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
      phase != PH_EXEC |-> mem_addr == ip);
   // R3
   data_addr_chk: assert property (@(posedge clk) disable iff (rst)
      phase == PH_EXEC |-> mem_addr == data_addr);
   // R4
   ip_step_chk: assert property (@(posedge clk) disable iff (rst)
      phase != PH_EXEC |=> ip == AW'($past(ip) + 1'b1));
   // R6
   instr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      phase == PH_EXEC |=> $stable(instr));
   // R7
   jump_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && op == OP_JMP) |=>
         ip == AW'($past(ip) + AW'($signed($past(instr[DW-1:0])))));
   // R8
   jc_skip_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && op == OP_JC && !carry_in) |=> $stable(ip));
   // R9
   no_branch_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && op != OP_JMP && op != OP_JC) |=> $stable(ip));
endmodule

bind fbu_top fbu_chk #(
   .AW(AW), .DW(DW), .IW(IW), .PW(PW), .OP_W(OP_W), .OP_JMP(OP_JMP), .OP_JC(OP_JC)
) u_chk (
   .clk(clk), .rst(rst), .carry_in(carry_in), .data_addr(data_addr),
   .mem_addr(mem_addr), .ip(ip), .phase(phase), .instr(instr)
);

// File: tb/sim_fbu_top.sv
`timescale 1ns/1ps
module sim_fbu_top;
   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  mem_rdata, data_addr;
   logic        carry_in;
   logic [7:0]  mem_addr, ip, data_byte;
   logic [1:0]  phase;
   logic [15:0] instr;

   logic [7:0]  mem [256];
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;
   logic [7:0]  m_ip;

   fbu_top u0 (
      .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .data_addr(data_addr),
      .carry_in(carry_in), .mem_addr(mem_addr), .phase(phase), .ip(ip),
      .instr(instr), .data_byte(data_byte)
   );

   assign mem_rdata = mem[mem_addr];
   always #2.5 clk = ~clk;

   // {instr[15:0], carry, data address[7:0], data value[7:0]}
   localparam logic [32:0] VEC [11] = '{
      {16'h1234, 1'b1, 8'hA0, 8'h11},  // plain op, carry ignored
      {16'hC005, 1'b0, 8'hA1, 8'h22},  // jump +5 -> odd start
      {16'hE0FE, 1'b1, 8'hA2, 8'h33},  // carry branch -2, taken, odd start
      {16'hE010, 1'b0, 8'hA3, 8'h44},  // carry branch not taken
      {16'hC0F0, 1'b0, 8'hA4, 8'h55},  // jump -16 wraps below 0
      {16'h5A00, 1'b1, 8'hA5, 8'h66},  // plain op, ends at 255
      {16'h7777, 1'b0, 8'hA6, 8'h77},  // pair straddles 255/0
      {16'hC07F, 1'b0, 8'hA7, 8'h88},  // jump +127
      {16'hC080, 1'b1, 8'hA8, 8'h99},  // jump -128
      {16'hE003, 1'b1, 8'hA9, 8'hAA},  // carry branch +3
      {16'hE3F0, 1'b0, 8'hAA, 8'hBB}   // carry clear, no move
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic run_vec(input logic [15:0] ins, input logic cy,
                          input logic [7:0] da, input logic [7:0] dv);
      logic [7:0] a0, a1, ex;
      int         sum;
      string      tg;
      a0 = m_ip;
      a1 = m_ip + 8'd1;
      mem[a0] = a0[0] ? ins[7:0] : ins[15:8];
      mem[a1] = a1[0] ? ins[7:0] : ins[15:8];
      chk("R2 phase first fetch", {14'd0, phase}, 16'd0);
      chk("R3 addr first fetch", {8'd0, mem_addr}, {8'd0, a0});
      tick();
      chk("R4 ip after byte 1", {8'd0, ip}, {8'd0, a1});
      chk("R2 phase second fetch", {14'd0, phase}, 16'd1);
      chk("R3 addr second fetch", {8'd0, mem_addr}, {8'd0, a1});
      tick();
      chk("R4 ip after byte 2", {8'd0, ip}, {8'd0, a1 + 8'd1});
      chk("R2 phase execute", {14'd0, phase}, 16'd2);
      chk("R5 assembled instr", instr, ins);
      mem[da]   = dv;
      data_addr = da;
      carry_in  = cy;
      #1;
      chk("R3 addr execute", {8'd0, mem_addr}, {8'd0, da});
      ex  = a1 + 8'd1;
      sum = int'(ex);
      tg  = "R9 no branch";
      if (ins[15:12] == 4'b1100) begin
         sum = int'(ex) + int'($signed(ins[7:0]));
         tg  = "R7 jump";
      end else if (ins[15:12] == 4'b1110) begin
         tg = "R8 carry branch";
         if (cy) sum = int'(ex) + int'($signed(ins[7:0]));
      end
      if (sum < 0 || sum > 255) tg = "R10 branch wrap";
      ex = 8'(sum);
      tick();
      chk(tg, {8'd0, ip}, {8'd0, ex});
      chk("R6 data byte", {8'd0, data_byte}, {8'd0, dv});
      chk("R6 instr held", instr, ins);
      chk("R2 phase back to 0", {14'd0, phase}, 16'd0);
      carry_in = 1'b0;
      m_ip = ex;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
      rst = 1'b1; data_addr = 8'h00; carry_in = 1'b0;
      tick(); tick(); tick();
      // R1 reset state
      chk("R1 ip", {8'd0, ip}, 16'd0);
      chk("R1 phase", {14'd0, phase}, 16'd0);
      chk("R1 instr", instr, 16'd0);
      chk("R1 data", {8'd0, data_byte}, 16'd0);
      rst  = 1'b0;
      m_ip = 8'd0;

      for (int v = 0; v < 11; v++)
         run_vec(VEC[v][32:17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);

      // R1 reset in the middle of a fetch
      tick();
      rst = 1'b1;
      tick();
      chk("R1 mid-run ip", {8'd0, ip}, 16'd0);
      chk("R1 mid-run phase", {14'd0, phase}, 16'd0);
      chk("R1 mid-run instr", instr, 16'd0);
      chk("R1 mid-run data", {8'd0, data_byte}, 16'd0);
      rst  = 1'b0;
      m_ip = 8'd0;
      run_vec(16'hC0FF, 1'b0, 8'hB0, 8'h5C);  // R7 jump -1 after reset

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule